// File: doc/BRIEF.md
# Vector Prefix Decoder and Validator

This block sits at the front of an instruction decode pipe and consumes instruction bytes one per accepted cycle. When the first byte of an instruction is one of the two vector-extension escape values, it collects the one or two payload bytes that follow. From them it extracts the register-extension bits, the opcode map, the width bit, the vector-length bit, the implied legacy prefix code and the extra register specifier. Any other first byte completes at once with a no-prefix indication.

The short form leaves out several fields, and the block fills them with fixed defaults. Legality is judged against a small per-opcode descriptor driven by the surrounding decoder: a two-bit vector-length policy, a flag that says a 128-bit variant of a 256-bit opcode exists, and a two-bit role for the extra specifier. The descriptor is sampled in the cycle that the final prefix byte is accepted. Results are registered and appear one cycle later, together with a single-cycle done strobe and an invalid-opcode flag.

Top module: `vpfx_decoder`

## Requirements
- R1: A first byte of C4h starts the three-byte form and C5h starts the two-byte form. Any other accepted first byte raises out_done and out_nopfx on the next cycle, with out_ud low, out_long low and every field output zero.
- R2: Three-byte form: payload byte 1 holds inverted R, X and B in bits 7, 6 and 5 and the map code in bits 4:0. Payload byte 2 holds W in bit 7, the inverted specifier in bits 6:3, L in bit 2 and the prefix code in bits 1:0. out_r, out_x, out_b and out_spec are the complements of those bits, and out_long is 1.
- R3: Two-byte form: the payload byte holds inverted R in bit 7, the inverted specifier in bits 6:3, L in bit 2 and the prefix code in bits 1:0. out_x, out_b and out_w read 0, out_map reads 1 and out_long reads 0.
- R4: out_pp passes the prefix code through unchanged (00 none, 01 66h, 10 F3h, 11 F2h). Map codes 1, 2 and 3 give out_map 1, 2 and 3 (the 0F, 0F38 and 0F3A maps). Any other map code gives out_map 0 and raises out_ud.
- R5: When d_role is 00 (no operand), a raw specifier field other than 1111b raises out_ud.
- R6: With d_len_pol 00 (ignored), the L bit never raises out_ud and is still reported on out_l.
- R7: With d_len_pol 01 (must be zero), L=1 raises out_ud.
- R8: With d_len_pol 10 (256-only), L=0 raises out_ud unless d_alt128 is 1. In that case decode proceeds with out_l = 0.
- R9: With d_len_pol 11 (128-only), L=1 raises out_ud.
- R10: For a prefixed instruction, out_role reports d_role (00 none, 01 preserved first source, 10 destination, 11 second source of a destructive form). It reads 00 otherwise.
- R11: out_done rises for exactly one cycle, one cycle after the final prefix byte. out_ud is only ever high in such a cycle.
- R12: Cycles with in_valid low leave collection state unchanged. A synchronous reset returns the collector to idle, discards a partial prefix and clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | in_byte is offered this cycle |
| in_byte | input | 8 | Instruction byte |
| d_len_pol | input | 2 | Vector-length policy of the opcode |
| d_alt128 | input | 1 | A 128-bit variant of a 256-only opcode exists |
| d_role | input | 2 | Role of the extra register specifier |
| out_done | output | 1 | Decode result valid, one cycle |
| out_nopfx | output | 1 | Instruction had no vector prefix |
| out_long | output | 1 | Three-byte form was decoded |
| out_ud | output | 1 | Invalid-opcode flag |
| out_r | output | 1 | Register extension R, true polarity |
| out_x | output | 1 | Index extension X, true polarity |
| out_b | output | 1 | Base extension B, true polarity |
| out_w | output | 1 | Width bit |
| out_l | output | 1 | Vector-length bit |
| out_map | output | 2 | Opcode map: 1, 2, 3 valid, 0 none or invalid |
| out_pp | output | 2 | Implied legacy prefix code |
| out_spec | output | 4 | Extra register specifier, true polarity |
| out_role | output | 2 | Role of the extra specifier |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, the standard escape values and strict map checking. At that size every non-escape first byte can be swept. The two-byte form can be swept over every prefix code, L value, specifier value and R bit, crossed with every length policy, every role and both settings of the 128-bit-variant flag. The three-byte form is swept over all 32 map codes against the length policies, the alternate-variant flag, used and unused specifier roles, and both a valid and an invalid specifier. Directed cases cover idle gaps between prefix bytes and a reset in the middle of a prefix.

// File: rtl/vpfx_pkg.sv
package vpfx_pkg;
   localparam int SPEC_W = 4;
   localparam int MAP_W  = 2;

   typedef enum logic [1:0] {
      COL_IDLE  = 2'd0,
      COL_TAKE1 = 2'd1,
      COL_TAKE2 = 2'd2
   } col_state_e;

   typedef enum logic [1:0] {
      FORM_NONE  = 2'd0,
      FORM_SHORT = 2'd1,
      FORM_LONG  = 2'd2
   } form_e;

   typedef enum logic [1:0] {
      LP_IGNORE  = 2'd0,
      LP_ZERO    = 2'd1,
      LP_ONLY256 = 2'd2,
      LP_ONLY128 = 2'd3
   } len_pol_e;

   typedef struct packed {
      logic              r;
      logic              x;
      logic              b;
      logic              w;
      logic              l;
      logic [MAP_W-1:0]  map;
      logic              map_ok;
      logic [1:0]        pp;
      logic [SPEC_W-1:0] spec_raw;
   } vfields_t;
endpackage

// File: rtl/vpfx_collect.sv
module vpfx_collect
   import vpfx_pkg::*;
#(
   parameter int          BW        = 8,
   parameter logic [7:0]  ESC_LONG  = 8'hC4,
   parameter logic [7:0]  ESC_SHORT = 8'hC5
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_valid,
   input  logic [BW-1:0] in_byte,
   output logic          fin,
   output form_e         form,
   output logic [BW-1:0] p1,
   output logic [BW-1:0] p2
);
   col_state_e    state_q, state_d;
   logic          long_q;
   logic [BW-1:0] b1_q;
   logic          is_long, is_short;

   if (BW != 8) begin : g_bad_bw
      $error("vpfx_collect: BW must be 8");
   end

   assign is_long  = (in_byte == BW'(ESC_LONG));
   assign is_short = (in_byte == BW'(ESC_SHORT));

   always_comb begin
      state_d = state_q;
      fin     = 1'b0;
      form    = FORM_NONE;
      p1      = in_byte;
      p2      = in_byte;
      if (in_valid) begin
         unique case (state_q)
            COL_IDLE: begin
               if (is_long || is_short) state_d = COL_TAKE1;
               else begin
                  fin  = 1'b1;
                  form = FORM_NONE;
               end
            end
            COL_TAKE1: begin
               if (long_q) state_d = COL_TAKE2;
               else begin
                  state_d = COL_IDLE;
                  fin     = 1'b1;
                  form    = FORM_SHORT;
               end
            end
            COL_TAKE2: begin
               state_d = COL_IDLE;
               fin     = 1'b1;
               form    = FORM_LONG;
               p1      = b1_q;
            end
            default: state_d = COL_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= COL_IDLE;
         long_q  <= 1'b0;
         b1_q    <= '0;
      end else begin
         state_q <= state_d;
         if (in_valid && state_q == COL_IDLE) long_q <= is_long;
         if (in_valid && state_q == COL_TAKE1) b1_q <= in_byte;
      end
   end

   AST_RESET_IDLE: assert property (@(posedge clk) $past(rst) |-> state_q == COL_IDLE); // R12
   AST_HOLD_NO_VALID: assert property (@(posedge clk) disable iff (rst)
      !$past(in_valid) && !$past(rst) |-> $stable(state_q)); // R12
endmodule

// File: rtl/vpfx_fields.sv
module vpfx_fields
   import vpfx_pkg::*;
#(
   parameter int BW    = 8,
   parameter int MCODE = 5
) (
   input  form_e         form,
   input  logic [BW-1:0] p1,
   input  logic [BW-1:0] p2,
   output vfields_t      fld
);
   logic [MCODE-1:0] mraw;

   if (MCODE + 3 != BW) begin : g_bad_mcode
      $error("vpfx_fields: map code width must leave room for R, X, B");
   end

   assign mraw = p1[MCODE-1:0];

   always_comb begin
      fld          = '0;
      fld.spec_raw = '1;
      unique case (form)
         FORM_SHORT: begin
            fld.r        = ~p1[7];
            fld.spec_raw = p1[6:3];
            fld.l        = p1[2];
            fld.pp       = p1[1:0];
            fld.map      = MAP_W'(1);
            fld.map_ok   = 1'b1;
         end
         FORM_LONG: begin
            fld.r        = ~p1[7];
            fld.x        = ~p1[6];
            fld.b        = ~p1[5];
            fld.w        = p2[7];
            fld.spec_raw = p2[6:3];
            fld.l        = p2[2];
            fld.pp       = p2[1:0];
            fld.map_ok   = (mraw >= MCODE'(1)) && (mraw <= MCODE'(3));
            fld.map      = fld.map_ok ? mraw[MAP_W-1:0] : '0;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/vpfx_legal.sv
module vpfx_legal
   import vpfx_pkg::*;
#(
   parameter bit STRICT_MAP = 1'b1
) (
   input  form_e      form,
   input  vfields_t   fld,
   input  logic [1:0] len_pol,
   input  logic       alt128,
   input  logic [1:0] role,
   output logic       ud
);
   logic spec_bad, len_bad, map_bad;

   assign spec_bad = (role == 2'b00) && (fld.spec_raw != '1);

   always_comb begin
      unique case (len_pol_e'(len_pol))
         LP_ZERO:    len_bad = fld.l;
         LP_ONLY256: len_bad = !fld.l && !alt128;
         LP_ONLY128: len_bad = fld.l;
         default:    len_bad = 1'b0;
      endcase
   end

   if (STRICT_MAP) begin : g_map_strict
      assign map_bad = !fld.map_ok;
   end else begin : g_map_loose
      assign map_bad = 1'b0;
   end

   assign ud = (form != FORM_NONE) && (spec_bad || len_bad || map_bad);
endmodule

// File: rtl/vpfx_decoder.sv
module vpfx_decoder
   import vpfx_pkg::*;
#(
   parameter int         BW         = 8,
   parameter logic [7:0] ESC_LONG   = 8'hC4,
   parameter logic [7:0] ESC_SHORT  = 8'hC5,
   parameter bit         STRICT_MAP = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_valid,
   input  logic [BW-1:0] in_byte,
   input  logic [1:0]    d_len_pol,
   input  logic          d_alt128,
   input  logic [1:0]    d_role,
   output logic          out_done,
   output logic          out_nopfx,
   output logic          out_long,
   output logic          out_ud,
   output logic          out_r,
   output logic          out_x,
   output logic          out_b,
   output logic          out_w,
   output logic          out_l,
   output logic [1:0]    out_map,
   output logic [1:0]    out_pp,
   output logic [3:0]    out_spec,
   output logic [1:0]    out_role
);
   localparam int MCODE = BW - 3;

   logic          fin, ud_c;
   form_e         form;
   logic [BW-1:0] p1, p2;
   vfields_t      fld;

   if (ESC_LONG == ESC_SHORT) begin : g_bad_esc
      $error("vpfx_decoder: escape values must differ");
   end

   vpfx_collect #(.BW(BW), .ESC_LONG(ESC_LONG), .ESC_SHORT(ESC_SHORT)) u_col (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
      .fin(fin), .form(form), .p1(p1), .p2(p2));

   vpfx_fields #(.BW(BW), .MCODE(MCODE)) u_fld (
      .form(form), .p1(p1), .p2(p2), .fld(fld));

   vpfx_legal #(.STRICT_MAP(STRICT_MAP)) u_leg (
      .form(form), .fld(fld), .len_pol(d_len_pol), .alt128(d_alt128),
      .role(d_role), .ud(ud_c));

   always_ff @(posedge clk) begin
      if (rst) begin
         out_done  <= 1'b0;
         out_nopfx <= 1'b0;
         out_long  <= 1'b0;
         out_ud    <= 1'b0;
         out_r     <= 1'b0;
         out_x     <= 1'b0;
         out_b     <= 1'b0;
         out_w     <= 1'b0;
         out_l     <= 1'b0;
         out_map   <= '0;
         out_pp    <= '0;
         out_spec  <= '0;
         out_role  <= '0;
      end else begin
         out_done <= fin;
         out_ud   <= fin && ud_c;
         if (fin) begin
            out_nopfx <= (form == FORM_NONE);
            out_long  <= (form == FORM_LONG);
            out_r     <= fld.r;
            out_x     <= fld.x;
            out_b     <= fld.b;
            out_w     <= fld.w;
            out_l     <= fld.l;
            out_map   <= fld.map;
            out_pp    <= fld.pp;
            out_spec  <= ~fld.spec_raw;
            out_role  <= (form == FORM_NONE) ? 2'b00 : d_role;
         end
      end
   end

   AST_UD_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
      out_ud |-> out_done); // R11
   AST_UD_SINGLE: assert property (@(posedge clk) disable iff (rst)
      out_ud |=> !out_ud); // R11
   AST_NOPFX_CLEAN: assert property (@(posedge clk) disable iff (rst)
      out_done && out_nopfx |-> !out_ud && !out_long && out_role == 2'b00); // R1
   AST_SHORT_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
      out_done && !out_nopfx && !out_long |-> out_map == 2'd1 && !out_x && !out_b && !out_w); // R3
   AST_UNUSED_SPEC: assert property (@(posedge clk) disable iff (rst)
      out_done && !out_nopfx && out_role == 2'b00 && !out_ud |-> out_spec == 4'd0); // R5
endmodule

// File: tb/tb_vpfx_decoder.sv
`timescale 1ns/1ps
module tb_vpfx_decoder;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       in_valid = 1'b0;
   logic [7:0] in_byte = 8'h00;
   logic [1:0] d_len_pol = 2'b00;
   logic       d_alt128 = 1'b0;
   logic [1:0] d_role = 2'b00;
   logic       out_done, out_nopfx, out_long, out_ud;
   logic       out_r, out_x, out_b, out_w, out_l;
   logic [1:0] out_map, out_pp, out_role;
   logic [3:0] out_spec;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   vpfx_decoder dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
      .d_len_pol(d_len_pol), .d_alt128(d_alt128), .d_role(d_role),
      .out_done(out_done), .out_nopfx(out_nopfx), .out_long(out_long),
      .out_ud(out_ud), .out_r(out_r), .out_x(out_x), .out_b(out_b),
      .out_w(out_w), .out_l(out_l), .out_map(out_map), .out_pp(out_pp),
      .out_spec(out_spec), .out_role(out_role));

   function automatic logic [18:0] outs();
      return {out_done, out_nopfx, out_long, out_ud, out_r, out_x, out_b,
              out_w, out_l, out_map, out_pp, out_spec, out_role};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [18:0] act,
                      input logic [18:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Expected outputs computed from the requirement text.
   function automatic logic [18:0] model(input int n, input logic [7:0] b0,
      input logic [7:0] b1, input logic [7:0] b2, input logic [1:0] pol,
      input logic alt, input logic [1:0] role);
      logic nop, lng, ud, r, x, b, w, l;
      logic [1:0] map, pp, ro;
      logic [3:0] spec, vraw;
      logic [4:0] m;
      nop = 0; lng = 0; ud = 0; r = 0; x = 0; b = 0; w = 0; l = 0;
      map = 0; pp = 0; ro = 0; spec = 0; vraw = 4'hF;
      if (n == 1) nop = 1;
      else begin
         ro = role;
         r = ~b1[7];
         if (n == 2) begin
            vraw = b1[6:3]; l = b1[2]; pp = b1[1:0]; map = 2'd1;
         end else begin
            lng = 1; x = ~b1[6]; b = ~b1[5]; m = b1[4:0];
            w = b2[7]; vraw = b2[6:3]; l = b2[2]; pp = b2[1:0];
            if (m >= 1 && m <= 3) map = m[1:0];
            else ud = 1;
         end
         spec = ~vraw;
         if (role == 2'b00 && vraw != 4'hF) ud = 1;
         if (pol == 2'b01 && l) ud = 1;
         if (pol == 2'b11 && l) ud = 1;
         if (pol == 2'b10 && !l && !alt) ud = 1;
      end
      return {1'b1, nop, lng, ud, r, x, b, w, l, map, pp, spec, ro};
   endfunction

   task automatic xact(input int n, input logic [7:0] b0, input logic [7:0] b1,
      input logic [7:0] b2, input logic [1:0] pol, input logic alt,
      input logic [1:0] role, input string tag);
      logic [7:0] bs [3];
      logic [18:0] e;
      bs[0] = b0; bs[1] = b1; bs[2] = b2;
      d_len_pol = pol; d_alt128 = alt; d_role = role;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b1; in_byte = bs[i];
      end
      @(negedge clk);
      in_valid = 1'b0;
      e = model(n, b0, b1, b2, pol, alt, role);
      chk(outs() == e, tag, outs(), e);
      @(negedge clk);
      chk(!out_done && !out_ud, "R11 done pulse", outs(), 19'd0);
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R12: reset clears outputs even with a byte offered
      in_valid = 1'b1; in_byte = 8'hC4;
      repeat (3) @(negedge clk);
      chk(outs() == 19'd0, "R12 reset state", outs(), 19'd0);
      in_valid = 1'b0;
      @(negedge clk);
      rst = 1'b0;

      // R1: every non-escape first byte
      for (int v = 0; v < 256; v++)
         if (v != 'hC4 && v != 'hC5)
            xact(1, 8'(v), 8'h00, 8'h00, 2'b00, 1'b0, 2'b00, "R1 no prefix");

      // R3 R4 R5 R6 R7 R8 R9 R10: two-byte form sweep
      for (int pp = 0; pp < 4; pp++)
         for (int l = 0; l < 2; l++)
            for (int v = 0; v < 16; v++)
               for (int pol = 0; pol < 4; pol++)
                  for (int alt = 0; alt < 2; alt++)
                     for (int ro = 0; ro < 4; ro++)
                        for (int r = 0; r < 2; r++)
                           xact(2, 8'hC5, {1'(r), 4'(v), 1'(l), 2'(pp)}, 8'h00,
                                2'(pol), 1'(alt), 2'(ro), "R3/R5/R6/R7/R8/R9/R10 short");

      // R2 R4 R8: three-byte form sweep over every map code
      for (int m = 0; m < 32; m++)
         for (int l = 0; l < 2; l++)
            for (int pol = 0; pol < 4; pol++)
               for (int alt = 0; alt < 2; alt++)
                  for (int ro = 0; ro < 2; ro++)
                     for (int vs = 0; vs < 2; vs++)
                        xact(3, 8'hC4, {3'(m % 8), 5'(m)},
                             {1'(l ^ m), (vs != 0) ? 4'hF : 4'h5, 1'(l), 2'(m % 4)},
                             2'(pol), 1'(alt), 2'(ro * 2), "R2/R4/R8 long");

      // R12: idle gaps between prefix bytes
      d_len_pol = 2'b00; d_alt128 = 1'b0; d_role = 2'b01;
      @(negedge clk); in_valid = 1'b1; in_byte = 8'hC4;
      @(negedge clk); in_valid = 1'b0;
      @(negedge clk);
      @(negedge clk); in_valid = 1'b1; in_byte = 8'h62;
      @(negedge clk); in_valid = 1'b0;
      chk(!out_done, "R12 gap hold", outs(), 19'd0);
      @(negedge clk); in_valid = 1'b1; in_byte = 8'h9D;
      @(negedge clk); in_valid = 1'b0;
      chk(outs() == model(3, 8'hC4, 8'h62, 8'h9D, 2'b00, 1'b0, 2'b01),
          "R12 gap result", outs(), model(3, 8'hC4, 8'h62, 8'h9D, 2'b00, 1'b0, 2'b01));

      // R12: reset mid-prefix discards it
      @(negedge clk); in_valid = 1'b1; in_byte = 8'hC4;
      @(negedge clk); in_valid = 1'b0; rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      xact(1, 8'h90, 8'h00, 8'h00, 2'b00, 1'b0, 2'b00, "R12 reset mid-prefix");

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule